// File: doc/BRIEF.md
# DRAM Bank Expander with Refresh Extension

This block lets a processor with a 16-bit address reach a 256 KB multiplexed-address DRAM array. The array is treated as four 64 KB codes of four 16 KB slots each. A 3-bit bank number is held in an I/O port register. Software sets that register either with a full-byte write to one port address or with a single-bit set/reset command written to a second port address. The block adds two multiplexed DRAM address lines. Like the existing eight lines, each new line carries one bit in the row half of the access and another bit in the column half.

Only the lower 48 KB of the processor space (address bits 15:14 not both 1) follows the bank number. The top 16 KB is a common area that always lands in the fixed slot 3 of code 0. Bank numbers 0 to 3 select code 0 to 3 for the lower area. Bank 4 is packed into the otherwise unused slot 3 of codes 1 to 3. Bank 5 behaves as bank 4, and banks 6 and 7 behave as bank 0, so the five banks and the common area fill the array with no overlap.

The processor's own refresh counter does not cover the added row bits. A private counter therefore advances once per refresh strobe, and during a refresh its value is driven onto the new lines.

Top module: `dram_bank_expander`

## Requirements
- R1: After synchronous reset the bank register is 0, the refresh counter is 0 and `xaddr_o` is 2'b00.
- R2: A write with `io_we_i`=1 to `io_addr_i`=8'h57 loads the bank number from data bits 7 (MSB), 6 and 4 (LSB). The other data bits are ignored.
- R3: A write to `io_addr_i`=8'h54 with data bit 7 = 0 is a bit command. Data bits 3:1 give a port bit index n and data bit 0 gives the new value. For n = 4, 6 or 7 the bank bit 0, 1 or 2 respectively takes that value. Any other n, or data bit 7 = 1, leaves the bank unchanged.
- R4: Writes to any other port address, or with `io_we_i`=0, leave the bank unchanged.
- R5: Outside refresh, with address bits 15:14 not 2'b11 and effective bank b in 0..3, the line pair `{xaddr_o[1],xaddr_o[0]}` is b during the row half (`row_sel_i`=1) and address bits 15:14 during the column half.
- R6: With effective bank 4 and address bits 15:14 = a not 2'b11, the line pair is a+1 in the row half and 2'b11 in the column half.
- R7: Bank 5 maps exactly as bank 4. Banks 6 and 7 map exactly as bank 0.
- R8: With address bits 15:14 = 2'b11 and no refresh, the line pair is 2'b00 in the row half and 2'b11 in the column half, whatever the bank.
- R9: While `rfsh_i`=1 the line pair equals the refresh counter, whatever the bank, the address and the phase.
- R10: The 2-bit refresh counter increments by one, wrapping modulo 4, on the first clock edge at which `rfsh_i` is sampled 0 after being sampled 1.
- R11: `xaddr_o` is registered. It reflects the inputs sampled at a clock edge and the bank and counter state held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_we_i | input | 1 | I/O write strobe |
| io_addr_i | input | 8 | I/O port address |
| io_data_i | input | 8 | I/O write data |
| cpu_hi_i | input | 2 | Processor address bits 15:14 |
| row_sel_i | input | 1 | 1 = row half of the DRAM address, 0 = column half |
| rfsh_i | input | 1 | Refresh cycle strobe, active high |
| xaddr_o | output | 2 | Added multiplexed DRAM address lines |

## Verification
The bench targets the folded bank numbers. An expander that aliased bank 5, 6 or 7 wrongly would place data in another bank's slots, and the row-half code shows this at once. It drives the common area under every bank number, because a design that let the bank leak into the top 16 KB would give back a nonzero row code there. It sends bit commands with unused indices and with bit 7 set, and writes to neighbouring addresses. A decoder that was too loose would change the bank, and the next lower-area read would show it. It also runs long refresh pulses and more than four pulses in a row, which catches a counter that steps on every cycle of the strobe or does not wrap.

// File: rtl/dram_bank_pkg.sv
package dram_bank_pkg;
  localparam int XLINES = 2;
  localparam int BANK_W = 3;
  typedef logic [XLINES-1:0] xpair_t;
  typedef logic [BANK_W-1:0] bank_t;

  function automatic bank_t fold_bank(input bank_t b);
    if (b == 3'd5) return 3'd4;
    if (b >= 3'd6) return 3'd0;
    return b;
  endfunction
endpackage

// File: rtl/bank_port.sv
module bank_port
  import dram_bank_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] DATA_ADDR = 8'h57,
  parameter logic [AW-1:0] CMD_ADDR = 8'h54,
  parameter int POS_LO = 4,
  parameter int POS_MID = 6,
  parameter int POS_HI = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output bank_t         bank_o
);
  localparam int SELW = $clog2(DW);
  logic [SELW-1:0] cmd_sel;
  logic            cmd_ok;

  assign cmd_sel = data_i[SELW:1];
  assign cmd_ok  = we_i && (addr_i == CMD_ADDR) && !data_i[DW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_o <= '0;
    end else if (we_i && addr_i == DATA_ADDR) begin
      bank_o <= {data_i[POS_HI], data_i[POS_MID], data_i[POS_LO]};
    end else if (cmd_ok) begin
      if (cmd_sel == SELW'(POS_LO))  bank_o[0] <= data_i[0];
      if (cmd_sel == SELW'(POS_MID)) bank_o[1] <= data_i[0];
      if (cmd_sel == SELW'(POS_HI))  bank_o[2] <= data_i[0];
    end
  end

  // R4: writes that hit neither port leave the bank alone
  a_r4_foreign_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (!we_i || (addr_i != DATA_ADDR && addr_i != CMD_ADDR)) |=> $stable(bank_o));
  // R3: a bit command never touches more than one bank bit
  a_r3_single_bit: assert property (@(posedge clk) disable iff (rst)
    (we_i && addr_i == CMD_ADDR) |=> $countones(bank_o ^ $past(bank_o)) <= 1);
endmodule

// File: rtl/seg_map.sv
module seg_map
  import dram_bank_pkg::*;
(
  input  bank_t  bank_i,
  input  xpair_t cpu_hi_i,
  output xpair_t code_o,
  output xpair_t slot_o
);
  bank_t eff;
  assign eff = fold_bank(bank_i);

  always_comb begin
    if (cpu_hi_i == '1) begin
      code_o = '0;
      slot_o = '1;
    end else if (eff == 3'd4) begin
      code_o = cpu_hi_i + 1'b1;
      slot_o = '1;
    end else begin
      code_o = eff[XLINES-1:0];
      slot_o = cpu_hi_i;
    end
  end
endmodule

// File: rtl/refresh_ctr.sv
module refresh_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rfsh_i,
  output logic [CW-1:0] cnt_o
);
  logic rfsh_q;
  logic done;
  assign done = rfsh_q && !rfsh_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      rfsh_q <= 1'b0;
      cnt_o  <= '0;
    end else begin
      rfsh_q <= rfsh_i;
      if (done) cnt_o <= cnt_o + 1'b1;
    end
  end

  // R10: one step per finished refresh strobe, none otherwise
  a_r10_step: assert property (@(posedge clk) disable iff (rst)
    done |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(cnt_o));
endmodule

// File: rtl/dram_bank_expander.sv
module dram_bank_expander
  import dram_bank_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] DATA_ADDR = 8'h57,
  parameter logic [AW-1:0] CMD_ADDR = 8'h54
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          io_we_i,
  input  logic [AW-1:0] io_addr_i,
  input  logic [DW-1:0] io_data_i,
  input  logic [1:0]    cpu_hi_i,
  input  logic          row_sel_i,
  input  logic          rfsh_i,
  output logic [1:0]    xaddr_o
);
  bank_t  bank;
  xpair_t code, slot, rcnt;

  bank_port #(.AW(AW), .DW(DW), .DATA_ADDR(DATA_ADDR), .CMD_ADDR(CMD_ADDR))
    u_port (.clk(clk), .rst(rst), .we_i(io_we_i), .addr_i(io_addr_i),
            .data_i(io_data_i), .bank_o(bank));

  seg_map u_map (.bank_i(bank), .cpu_hi_i(cpu_hi_i), .code_o(code), .slot_o(slot));

  refresh_ctr #(.CW(XLINES)) u_rc (.clk(clk), .rst(rst), .rfsh_i(rfsh_i), .cnt_o(rcnt));

  for (genvar g = 0; g < XLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)            xaddr_o[g] <= 1'b0;
      else if (rfsh_i)    xaddr_o[g] <= rcnt[g];
      else if (row_sel_i) xaddr_o[g] <= code[g];
      else                xaddr_o[g] <= slot[g];
    end
  end

  // R8: common area is bank independent
  a_r8_common_row: assert property (@(posedge clk) disable iff (rst)
    (!rfsh_i && cpu_hi_i == 2'b11 && row_sel_i) |=> xaddr_o == 2'b00);
  a_r8_common_col: assert property (@(posedge clk) disable iff (rst)
    (!rfsh_i && cpu_hi_i == 2'b11 && !row_sel_i) |=> xaddr_o == 2'b11);
  // R9: refresh drives the counter onto the lines
  a_r9_refresh: assert property (@(posedge clk) disable iff (rst)
    rfsh_i |=> xaddr_o == $past(rcnt));
  // R6: bank 4 column half always uses slot 3
  a_r6_bank4_col: assert property (@(posedge clk) disable iff (rst)
    (!rfsh_i && !row_sel_i && bank == 3'd4) |=> xaddr_o == 2'b11);
endmodule

// File: tb/dram_bank_expander_tb_top.sv
module dram_bank_expander_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [7:0] addr = '0, data = '0;
  logic [1:0] hi = '0;
  logic row = 1'b1, rf = 1'b0;
  logic [1:0] xo;

  int total = 0, bad = 0;
  logic [2:0] m_bank = '0;
  logic [1:0] m_cnt = '0;
  logic m_rfq = 1'b0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  dram_bank_expander dut_i (.clk(clk), .rst(rst), .io_we_i(we), .io_addr_i(addr),
    .io_data_i(data), .cpu_hi_i(hi), .row_sel_i(row), .rfsh_i(rf), .xaddr_o(xo));

  function automatic logic [1:0] exp_x(input logic [2:0] b, input logic [1:0] a,
                                       input logic r, input logic f, input logic [1:0] c);
    logic [2:0] e;
    if (f) return c;
    if (a == 2'b11) return r ? 2'b00 : 2'b11;
    e = (b == 3'd5) ? 3'd4 : (b >= 3'd6) ? 3'd0 : b;
    if (e == 3'd4) return r ? a + 2'b01 : 2'b11;
    return r ? e[1:0] : a;
  endfunction

  function automatic logic [2:0] next_bank(input logic [2:0] b, input logic w,
                                           input logic [7:0] ad, input logic [7:0] d);
    logic [2:0] n = b;
    if (!w) return b;
    if (ad == 8'h57) return {d[7], d[6], d[4]};
    if (ad == 8'h54 && !d[7]) begin
      if (d[3:1] == 3'd4) n[0] = d[0];
      if (d[3:1] == 3'd6) n[1] = d[0];
      if (d[3:1] == 3'd7) n[2] = d[0];
    end
    return n;
  endfunction

  function automatic string tag_of(input logic [2:0] b, input logic [1:0] a, input logic f);
    if (f) return "R9";
    if (a == 2'b11) return "R8";
    if (b >= 3'd5) return "R7";
    if (b == 3'd4) return "R6";
    return "R5";
  endfunction

  // one clock: drive at negedge, check after the edge, then advance the model (R11)
  task automatic step(input logic w, input logic [7:0] ad, input logic [7:0] d,
                      input logic [1:0] a, input logic r, input logic f, input string extra);
    logic [1:0] e;
    @(negedge clk);
    we = w; addr = ad; data = d; hi = a; row = r; rf = f;
    e = exp_x(m_bank, a, r, f, m_cnt);
    @(posedge clk); #2;
    total++;
    if (xo !== e) begin
      bad++;
      $display("FAIL %s %s (R11): bank=%0d hi=%0d row=%0b rf=%0b got=%b exp=%b",
               tag_of(m_bank, a, f), extra, m_bank, a, r, f, xo, e);
    end
    m_bank = next_bank(m_bank, w, ad, d);
    if (m_rfq && !f) m_cnt = m_cnt + 2'd1;
    m_rfq = f;
  endtask

  task automatic wr(input logic [7:0] ad, input logic [7:0] d, input string t);
    step(1'b1, ad, d, 2'b00, 1'b1, 1'b0, t);
  endtask

  // probe the bank through a row read and a column read of the lower area
  task automatic probe(input string t);
    step(1'b0, 8'h00, 8'h00, 2'b01, 1'b1, 1'b0, t);
    step(1'b0, 8'h00, 8'h00, 2'b01, 1'b0, 1'b0, t);
  endtask

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    step(1'b0, 8'h00, 8'h00, 2'b00, 1'b1, 1'b1, "R1 counter");
    step(1'b0, 8'h00, 8'h00, 2'b10, 1'b1, 1'b0, "R1 bank");
    step(1'b0, 8'h00, 8'h00, 2'b10, 1'b0, 1'b0, "R1 col");
    // R2: full-byte writes, other bits ignored
    for (int b = 0; b < 8; b++) begin
      wr(8'h57, {b[2], b[1], 1'b1, b[0], 4'hF}, "R2 write");
      probe("R2");
      for (int a = 0; a < 4; a++) begin
        step(1'b0, 8'h00, 8'h00, 2'(a), 1'b1, 1'b0, "R5/R6/R7/R8 row");
        step(1'b0, 8'h00, 8'h00, 2'(a), 1'b0, 1'b0, "R5/R6/R7/R8 col");
      end
    end
    // R3: bit commands, valid and invalid indices, mode byte
    wr(8'h57, 8'h00, "R2 clear");
    wr(8'h54, 8'b0000_1001, "R3 set bit4");  probe("R3");
    wr(8'h54, 8'b0000_1111, "R3 set bit7");  probe("R3");
    wr(8'h54, 8'b0000_1011, "R3 bit5 none"); probe("R3");
    wr(8'h54, 8'b1000_1101, "R3 mode none"); probe("R3");
    wr(8'h54, 8'b0000_1101, "R3 set bit6");  probe("R3");
    wr(8'h54, 8'b0000_1000, "R3 clr bit4");  probe("R3");
    // R4: foreign addresses and disabled strobe
    wr(8'h56, 8'h00, "R4 other addr"); probe("R4");
    wr(8'h55, 8'h00, "R4 other addr"); probe("R4");
    step(1'b0, 8'h57, 8'h00, 2'b00, 1'b1, 1'b0, "R4 we low"); probe("R4");
    // R9/R10: long strobes, wrap beyond four pulses
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 3; k++)
        step(1'b0, 8'h00, 8'h00, 2'(k), k[0], 1'b1, "R10 pulse");
      step(1'b0, 8'h00, 8'h00, 2'b00, 1'b1, 1'b0, "R10 gap");
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] ad;
      logic [31:0] r = $urandom;
      ad = (r[1:0] == 2'd0) ? 8'h57 : (r[1:0] == 2'd1) ? 8'h54 : 8'(r[15:8]);
      step(r[2] & r[3], ad, 8'($urandom), 2'(r[5:4]), r[6], (r[9:7] == 3'd0), "random");
    end
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule